// File: doc/BRIEF.md
# Two-Level Interrupt In-Service Tracker

This block is the priority gate of an interrupt controller with two levels. Each source arrives already latched as a pending bit, with a second bit that places it in the high or the low group. The block tells the core whether a request could be taken (`irq_o`). When the core raises its acknowledge strobe, the block names one winning source in that same cycle: its index and its level.

Two hidden in-service flags record what the core is servicing. Taking a low request sets the low flag. Taking a high request sets both flags. A set low flag blocks further low grants. A set high flag blocks every grant. Software cannot read or write the flags. The only way to clear them is the return-from-interrupt strobe. Each return unwinds one level, the high flag first. After a high-level service, two returns are therefore needed before low requests can be taken again.

Top module: `isr_tracker`

## Requirements
- R1: After reset both in-service flags are clear, so the first acknowledged request of either level is granted.
- R2: While `glb_en_i` is 0, no grant is made and `irq_o` is 0, whatever the flags and pending bits.
- R3: `grant_vld_o` is 1 only in a cycle where `ack_i` is 1 and a grant is possible. In that same cycle `grant_idx_o` holds the winning source index and `grant_hi_o` holds its level (1 = high). `irq_o` shows that a grant is possible, even when `ack_i` is 0.
- R4: A source whose `prio_hi_i` bit is 1 belongs to the high group. When a high-group source can be granted, it wins over every low-group source.
- R5: Inside the winning group, the pending source with the lowest index is granted.
- R6: A low grant sets the low flag. From the next cycle on, no low request is granted until a return clears that flag.
- R7: While only the low flag is set, a high request is still granted (preemption).
- R8: A high grant sets both flags. From the next cycle on, no request of either level is granted until returns clear the flags.
- R9: A return clears the high flag if it is set, and clears the low flag otherwise. After a high grant, the first return still leaves low requests blocked, and the second return unblocks them.
- R10: A return while no flag is set has no effect: the next acknowledged low request is granted normally.
- R11: When a return and an acknowledge occur in the same cycle, eligibility is judged on the flags as they were before that cycle. The return's clear is applied first and the grant's set is applied after it, so the new grant's flags stay set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | NUM_SRC | Pending request bit per source |
| prio_hi_i | input | NUM_SRC | Level per source, 1 = high group |
| glb_en_i | input | 1 | Global interrupt enable |
| ack_i | input | 1 | Core acknowledge strobe |
| ret_i | input | 1 | Return-from-interrupt strobe |
| irq_o | output | 1 | A grant is currently possible |
| grant_vld_o | output | 1 | Grant issued this cycle |
| grant_idx_o | output | IDX_W | Index of the granted source |
| grant_hi_o | output | 1 | Level of the granted source |

## Verification
The bench builds the block with eight sources. This lets it put both ends of the index range, 0 and 7, into contention at the same time, and mix high and low sources in one pending mask. Eight sources also leave room to show lowest-index selection inside each group separately. The nesting scenarios drive the block through every flag combination, including returns issued in the same cycle as acknowledges.

// File: rtl/isr_pkg.sv
package isr_pkg;

    // In-service state: one flag per priority group
    typedef struct packed {
        logic hi;
        logic lo;
    } isr_flags_t;

    localparam int unsigned LEVELS = 2;
    localparam int unsigned LVL_LO = 0;
    localparam int unsigned LVL_HI = 1;

endpackage

// File: rtl/isr_pick.sv
// Fixed-order picker: lowest-numbered asserted request wins.
module isr_pick #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned IDX_W   = 3
) (
    input  logic [NUM_SRC-1:0] req_i,
    output logic               hit_o,
    output logic [IDX_W-1:0]   idx_o
);

    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/isr_arbiter.sv
// Splits requests by level, picks within each level, gates by in-service state.
module isr_arbiter
    import isr_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned IDX_W   = 3
) (
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] prio_hi_i,
    input  logic               glb_en_i,
    input  isr_flags_t         flags_i,
    output logic               elig_o,
    output logic               sel_hi_o,
    output logic [IDX_W-1:0]   sel_idx_o
);

    logic [NUM_SRC-1:0] lvl_req [LEVELS];
    logic               lvl_hit [LEVELS];
    logic [IDX_W-1:0]   lvl_idx [LEVELS];

    assign lvl_req[LVL_LO] = pend_i & ~prio_hi_i;
    assign lvl_req[LVL_HI] = pend_i &  prio_hi_i;

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        isr_pick #(
            .NUM_SRC(NUM_SRC),
            .IDX_W  (IDX_W)
        ) pick_i (
            .req_i(lvl_req[g]),
            .hit_o(lvl_hit[g]),
            .idx_o(lvl_idx[g])
        );
    end

    logic hi_ok;
    logic lo_ok;

    always_comb begin
        hi_ok     = glb_en_i && !flags_i.hi && lvl_hit[LVL_HI];
        lo_ok     = glb_en_i && !flags_i.hi && !flags_i.lo && lvl_hit[LVL_LO];
        elig_o    = hi_ok || lo_ok;
        sel_hi_o  = hi_ok;
        sel_idx_o = hi_ok ? lvl_idx[LVL_HI] : lvl_idx[LVL_LO];
    end

endmodule

// File: rtl/isr_flags.sv
// In-service flag pair: set by grants, unwound one level per return.
module isr_flags
    import isr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire_i,
    input  logic       fire_hi_i,
    input  logic       ret_i,
    output isr_flags_t flags_o
);

    isr_flags_t flags_d;
    isr_flags_t flags_q;

    always_comb begin
        flags_d = flags_q;
        if (ret_i) begin
            if (flags_q.hi) begin
                flags_d.hi = 1'b0;
            end else begin
                flags_d.lo = 1'b0;
            end
        end
        if (fire_i) begin
            flags_d.lo = 1'b1;
            if (fire_hi_i) begin
                flags_d.hi = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/isr_tracker.sv
module isr_tracker
    import isr_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8,
    localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] prio_hi_i,
    input  logic               glb_en_i,
    input  logic               ack_i,
    input  logic               ret_i,
    output logic               irq_o,
    output logic               grant_vld_o,
    output logic [IDX_W-1:0]   grant_idx_o,
    output logic               grant_hi_o
);

    isr_flags_t       flags;
    logic             elig;
    logic             sel_hi;
    logic [IDX_W-1:0] sel_idx;
    logic             fire;

    isr_arbiter #(
        .NUM_SRC(NUM_SRC),
        .IDX_W  (IDX_W)
    ) arb_i (
        .pend_i   (pend_i),
        .prio_hi_i(prio_hi_i),
        .glb_en_i (glb_en_i),
        .flags_i  (flags),
        .elig_o   (elig),
        .sel_hi_o (sel_hi),
        .sel_idx_o(sel_idx)
    );

    assign fire = elig && ack_i;

    isr_flags flags_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (fire),
        .fire_hi_i(sel_hi),
        .ret_i    (ret_i),
        .flags_o  (flags)
    );

    assign irq_o       = elig;
    assign grant_vld_o = fire;
    assign grant_idx_o = sel_idx;
    assign grant_hi_o  = sel_hi;

endmodule

// File: rtl/isr_tracker_chk.sv
module isr_tracker_chk #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned IDX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] pend_i,
    input logic [NUM_SRC-1:0] prio_hi_i,
    input logic               glb_en_i,
    input logic               ack_i,
    input logic               ret_i,
    input logic               irq_o,
    input logic               grant_vld_o,
    input logic [IDX_W-1:0]   grant_idx_o,
    input logic               grant_hi_o
);

    logic [NUM_SRC-1:0] below_mask;
    logic [NUM_SRC-1:0] grp_mask;
    assign below_mask = ({{(NUM_SRC-1){1'b0}}, 1'b1} << grant_idx_o) - 1'b1;
    assign grp_mask   = grant_hi_o ? prio_hi_i : ~prio_hi_i;

    AST_NO_GRANT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en_i |-> (!grant_vld_o && !irq_o)); // R2

    AST_GRANT_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld_o |-> (ack_i && irq_o)); // R3

    AST_GRANT_SOURCE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld_o |-> (pend_i[grant_idx_o] && (prio_hi_i[grant_idx_o] == grant_hi_o))); // R3

    AST_HI_OVER_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld_o && !grant_hi_o) |-> ((pend_i & prio_hi_i) == '0)); // R4

    AST_LOWEST_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld_o |-> ((pend_i & grp_mask & below_mask) == '0)); // R5

    AST_LO_BLOCKS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld_o && !grant_hi_o && !ret_i) |=> !(grant_vld_o && !grant_hi_o)); // R6

    AST_HI_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld_o && grant_hi_o && !ret_i) |=> !grant_vld_o); // R8

endmodule

bind isr_tracker isr_tracker_chk #(
    .NUM_SRC(NUM_SRC),
    .IDX_W  (IDX_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_i     (pend_i),
    .prio_hi_i  (prio_hi_i),
    .glb_en_i   (glb_en_i),
    .ack_i      (ack_i),
    .ret_i      (ret_i),
    .irq_o      (irq_o),
    .grant_vld_o(grant_vld_o),
    .grant_idx_o(grant_idx_o),
    .grant_hi_o (grant_hi_o)
);

// File: tb/isr_tracker_tb_top.sv
module isr_tracker_tb_top;

    localparam int unsigned N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pend_i = '0;
    logic [N-1:0] prio_hi_i = '0;
    logic         glb_en_i = 1'b0;
    logic         ack_i = 1'b0;
    logic         ret_i = 1'b0;
    logic         irq_o;
    logic         grant_vld_o;
    logic [2:0]   grant_idx_o;
    logic         grant_hi_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    isr_tracker #(.NUM_SRC(N)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_i     (pend_i),
        .prio_hi_i  (prio_hi_i),
        .glb_en_i   (glb_en_i),
        .ack_i      (ack_i),
        .ret_i      (ret_i),
        .irq_o      (irq_o),
        .grant_vld_o(grant_vld_o),
        .grant_idx_o(grant_idx_o),
        .grant_hi_o (grant_hi_o)
    );

    // One cycle: drive at falling edge, sample outputs 1 ns later.
    task automatic step(input logic [N-1:0] p, input logic [N-1:0] h,
                        input logic en, input logic ack, input logic ret,
                        input logic e_vld, input logic e_irq,
                        input int e_idx, input logic e_hi, input string tag);
        bit bad;
        @(negedge clk);
        pend_i = p; prio_hi_i = h; glb_en_i = en; ack_i = ack; ret_i = ret;
        #1;
        checks++;
        bad = (grant_vld_o !== e_vld) || (irq_o !== e_irq);
        if (e_vld && ((int'(grant_idx_o) != e_idx) || (grant_hi_o !== e_hi))) bad = 1'b1;
        if (bad) begin
            errors++;
            $display("FAIL %s: vld=%0b irq=%0b idx=%0d hi=%0b expected vld=%0b irq=%0b idx=%0d hi=%0b",
                     tag, grant_vld_o, irq_o, grant_idx_o, grant_hi_o, e_vld, e_irq, e_idx, e_hi);
        end
    endtask

    task automatic unwind();
        step('0, '0, 1, 0, 1, 0, 0, 0, 0, "unwind");
        step('0, '0, 1, 0, 1, 0, 0, 0, 0, "unwind");
    endtask

    task automatic t_reset();
        step('0, '0, 1, 0, 0, 0, 0, 0, 0, "R1 idle after reset");
        step(8'h10, '0, 1, 0, 0, 0, 1, 0, 0, "R3 irq without ack");
        step(8'h10, '0, 1, 1, 0, 1, 1, 4, 0, "R1 first grant");
        unwind();
    endtask

    task automatic t_enable();
        step(8'hFF, 8'h0F, 0, 1, 0, 0, 0, 0, 0, "R2 disabled");
        step(8'h04, '0, 1, 1, 0, 1, 1, 2, 0, "R2 enabled again");
        unwind();
    endtask

    task automatic t_priority();
        step(8'h81, 8'h80, 1, 1, 0, 1, 1, 7, 1, "R4 high index 7 beats low index 0");
        unwind();
        step(8'h6C, '0, 1, 1, 0, 1, 1, 2, 0, "R5 lowest low source");
        unwind();
        step(8'hF0, 8'hA0, 1, 1, 0, 1, 1, 5, 1, "R5 lowest high source");
        unwind();
    endtask

    task automatic t_nesting();
        step(8'h01, '0, 1, 1, 0, 1, 1, 0, 0, "R6 low grant");
        step(8'h02, '0, 1, 1, 0, 0, 0, 0, 0, "R6 low blocked");
        step(8'h08, 8'h08, 1, 1, 0, 1, 1, 3, 1, "R7 high preempts");
        step(8'h0A, 8'h08, 1, 1, 0, 0, 0, 0, 0, "R8 all blocked");
        step('0, '0, 1, 0, 1, 0, 0, 0, 0, "R9 first return");
        step(8'h02, '0, 1, 1, 0, 0, 0, 0, 0, "R9 low still blocked");
        step(8'h08, 8'h08, 1, 0, 0, 0, 1, 0, 0, "R9 high now possible");
        step('0, '0, 1, 0, 1, 0, 0, 0, 0, "R9 second return");
        step(8'h02, '0, 1, 1, 0, 1, 1, 1, 0, "R9 low granted after two returns");
        unwind();
    endtask

    task automatic t_spurious();
        step('0, '0, 1, 0, 1, 0, 0, 0, 0, "R10 return idle");
        step('0, '0, 1, 0, 1, 0, 0, 0, 0, "R10 return idle");
        step(8'h40, '0, 1, 1, 0, 1, 1, 6, 0, "R10 low granted after spurious returns");
        unwind();
        step(8'h20, '0, 1, 1, 1, 1, 1, 5, 0, "R11 return with ack, no flags");
        step(8'h20, '0, 1, 1, 0, 0, 0, 0, 0, "R11 new low flag kept");
        unwind();
    endtask

    task automatic t_same_cycle();
        step(8'h01, 8'h01, 1, 1, 0, 1, 1, 0, 1, "R8 high grant");
        step(8'h02, 8'h02, 1, 1, 1, 0, 0, 0, 0, "R11 old flags block");
        step(8'h02, 8'h02, 1, 1, 1, 1, 1, 1, 1, "R11 high granted with return");
        step(8'h04, '0, 1, 1, 0, 0, 0, 0, 0, "R11 both flags set again");
        step('0, '0, 1, 0, 1, 0, 0, 0, 0, "R9 return");
        step(8'h04, '0, 1, 1, 0, 0, 0, 0, 0, "R11 low flag survived");
        step('0, '0, 1, 0, 1, 0, 0, 0, 0, "R9 return");
        step(8'h04, '0, 1, 1, 0, 1, 1, 2, 0, "R11 fully unwound");
        unwind();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable();
        t_priority();
        t_nesting();
        t_spurious();
        t_same_cycle();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule